// File: doc/BRIEF.md
# GPIO Bank with Four-Mode Pad Control

A bank of up to 32 general-purpose pins, each of which can be a plain input, a push-pull output, a sink-only (open-drain, pulls low) output or a source-only (pulls high, floats low) output. Two mode bits per pin, together with that pin's output data bit, decide whether the pad is driven and to which level. Software reaches the bank through a small register window. Output data is changed only through atomic set and clear registers, so several agents can touch different pins without a read-modify-write.

The mode registers are protected by an external lock: any write that would change a mode bit is accepted only while `mode_unlock_i` is high. This includes the direct writes and the set and clear aliases. Pad inputs pass through a two-flop synchronizer into a read-only data-in register. The pin count is a parameter. Bits at or above the pin count are absent: they read 0 and ignore writes.

Top module: `gpio_mode_bank`

## Requirements
- R1: After reset, both mode registers and the output data register are 0, so every `pad_oe_o` bit is 0.
- R2: Reads return mode1 at address 0x08, mode0 at 0x0C and the output data register at 0x14. Address 0x18 and any address not listed in R2, R3, R9 or R10 read 0. Writes to unlisted addresses change nothing.
- R3: A write to 0x14 sets every output data bit whose write-data bit is 1. A write to 0x18 clears every output data bit whose write-data bit is 1. Bits written as 0 keep their value, and neither register depends on `mode_unlock_i`.
- R4: With {mode1,mode0} = 00 the pin's `pad_oe_o` is 0 whatever its data bit is. In every mode, `pad_out_o` is 0 whenever `pad_oe_o` is 0.
- R5: With {mode1,mode0} = 01 the pin's `pad_oe_o` is 1 and its `pad_out_o` equals its data bit.
- R6: With {mode1,mode0} = 10 the pin drives 0 (`pad_oe_o`=1, `pad_out_o`=0) when its data bit is 0, and floats when its data bit is 1.
- R7: With {mode1,mode0} = 11 the pin drives 1 (`pad_oe_o`=1, `pad_out_o`=1) when its data bit is 1, and floats when its data bit is 0.
- R8: While `mode_unlock_i` is 0, writes to 0x08, 0x0C, 0x50, 0x54 and 0x58 leave both mode registers unchanged.
- R9: While unlocked, a write to 0x08 or 0x0C loads mode1 or mode0 directly. A 1 written to a bit at 0x50 clears that mode1 bit, at 0x54 sets that mode0 bit, and at 0x58 clears that mode0 bit. Zeros written to these aliases change nothing.
- R10: Address 0x04 reads `pad_in_i` as it was two clock edges earlier, and writes to 0x04 change nothing.
- R11: Register bits at positions NPINS and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte address for both reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| mode_unlock_i | input | 1 | Write enable for the mode registers, from an external lock |
| pad_in_i | input | NPINS | Pad input levels, asynchronous |
| pad_out_o | output | NPINS | Level driven onto each pad |
| pad_oe_o | output | NPINS | Output enable of each pad |

## Verification
The assertions assume that `mode_unlock_i`, `reg_we_i`, `reg_addr_i` and `reg_wdata_i` are synchronous to `clk_i` and stable around its rising edge. `pad_in_i` is the only input allowed to change freely. The bench changes every input on the falling edge, so pad inputs look synchronous to the block. The two-edge data-in delay can therefore be predicted exactly rather than within a window. Lock toggling, alias writes and writes with bits above the pin count are mixed into a long pseudo-random phase, so locked and unlocked mode writes land against every pad mode.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_DIN   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MODE1 = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MODE0 = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DSET  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_DCLR  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_M1CLR = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_M0SET = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_M0CLR = 8'h58;

  // {mode1, mode0}
  typedef enum logic [1:0] {
    PAD_INPUT  = 2'b00,
    PAD_PUSH   = 2'b01,
    PAD_SINK   = 2'b10,
    PAD_SOURCE = 2'b11
  } pad_mode_e;
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wbits_i,
  input  logic              unlock_i,
  output logic [NPINS-1:0]  mode0_o,
  output logic [NPINS-1:0]  mode1_o,
  output logic [NPINS-1:0]  dout_o
);
  logic [NPINS-1:0] mode0_q, mode1_q, dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode0_q <= '0;
      mode1_q <= '0;
      dout_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_DSET:  dout_q <= dout_q | wbits_i;
        OFS_DCLR:  dout_q <= dout_q & ~wbits_i;
        OFS_MODE1: if (unlock_i) mode1_q <= wbits_i;
        OFS_MODE0: if (unlock_i) mode0_q <= wbits_i;
        OFS_M1CLR: if (unlock_i) mode1_q <= mode1_q & ~wbits_i;
        OFS_M0SET: if (unlock_i) mode0_q <= mode0_q | wbits_i;
        OFS_M0CLR: if (unlock_i) mode0_q <= mode0_q & ~wbits_i;
        default: ;
      endcase
    end
  end

  assign mode0_o = mode0_q;
  assign mode1_o = mode1_q;
  assign dout_o  = dout_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0] mode0_i,
  input  logic [NPINS-1:0] mode1_i,
  input  logic [NPINS-1:0] dout_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pad_mode_e mode;
    assign mode = pad_mode_e'({mode1_i[p], mode0_i[p]});

    always_comb begin
      pad_oe_o[p]  = 1'b0;
      pad_out_o[p] = 1'b0;
      unique case (mode)
        PAD_INPUT: ;
        PAD_PUSH: begin
          pad_oe_o[p]  = 1'b1;
          pad_out_o[p] = dout_i[p];
        end
        PAD_SINK: pad_oe_o[p] = ~dout_i[p];
        PAD_SOURCE: begin
          pad_oe_o[p]  = dout_i[p];
          pad_out_o[p] = dout_i[p];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] async_i,
  output logic [NPINS-1:0] sync_o
);
  logic [NPINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mode_bank.sv
module gpio_mode_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              mode_unlock_i,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o
);
  logic [NPINS-1:0] mode0_q, mode1_q, dout_q, din_q;

  gpio_bank_regs #(.NPINS(NPINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wbits_i  (reg_wdata_i[NPINS-1:0]),
    .unlock_i (mode_unlock_i),
    .mode0_o  (mode0_q),
    .mode1_o  (mode1_q),
    .dout_o   (dout_q)
  );

  gpio_pad_ctrl #(.NPINS(NPINS)) u_pad (
    .mode0_i   (mode0_q),
    .mode1_i   (mode1_q),
    .dout_i    (dout_q),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (din_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_DIN:   reg_rdata_o[NPINS-1:0] = din_q;
      OFS_MODE1: reg_rdata_o[NPINS-1:0] = mode1_q;
      OFS_MODE0: reg_rdata_o[NPINS-1:0] = mode0_q;
      OFS_DSET:  reg_rdata_o[NPINS-1:0] = dout_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_mode_bank_chk.sv
module gpio_mode_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [7:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             mode_unlock_i,
  input logic [NPINS-1:0] pad_in_i,
  input logic [NPINS-1:0] pad_out_o,
  input logic [NPINS-1:0] pad_oe_o,
  input logic [NPINS-1:0] mode0_q,
  input logic [NPINS-1:0] mode1_q,
  input logic [NPINS-1:0] dout_q,
  input logic [NPINS-1:0] din_q
);
  logic [1:0] edges_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edges_q <= '0;
    else if (edges_q != 2'd2) edges_q <= edges_q + 2'd1;
  end

  AST_UNDRIVEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0); // R4
  AST_INPUT_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~mode1_q & ~mode0_q) == '0); // R4
  AST_PUSH_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~mode1_q & mode0_q & ~pad_oe_o) == '0); // R5
  AST_SINK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode1_q & ~mode0_q & ~dout_q & ~pad_oe_o) == '0); // R6
  AST_SOURCE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode1_q & mode0_q & dout_q & ~(pad_oe_o & pad_out_o)) == '0); // R7
  AST_DATA_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_DSET) |=>
      ((dout_q & $past(reg_wdata_i[NPINS-1:0])) == $past(reg_wdata_i[NPINS-1:0]))); // R3
  AST_DATA_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_DCLR) |=>
      ((dout_q & $past(reg_wdata_i[NPINS-1:0])) == '0)); // R3
  AST_MODE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_unlock_i |=> $stable({mode1_q, mode0_q})); // R8
  AST_ALIAS_M0SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && mode_unlock_i && reg_addr_i == OFS_M0SET) |=>
      ((mode0_q & $past(reg_wdata_i[NPINS-1:0])) == $past(reg_wdata_i[NPINS-1:0]))); // R9
  AST_ALIAS_M1CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && mode_unlock_i && reg_addr_i == OFS_M1CLR) |=>
      ((mode1_q & $past(reg_wdata_i[NPINS-1:0])) == '0)); // R9
  AST_DIN_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q == 2'd2) |-> (din_q == $past(pad_in_i, 2))); // R10
endmodule

bind gpio_mode_bank gpio_mode_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .mode_unlock_i (mode_unlock_i),
  .pad_in_i      (pad_in_i),
  .pad_out_o     (pad_out_o),
  .pad_oe_o      (pad_oe_o),
  .mode0_q       (mode0_q),
  .mode1_q       (mode1_q),
  .dout_q        (dout_q),
  .din_q         (din_q)
);

// File: tb/gpio_mode_bank_tb.sv
module gpio_mode_bank_tb;
  localparam int N = 6;
  localparam logic [31:0] MASK = (32'd1 << N) - 32'd1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, unlock = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_mode_bank #(.NPINS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mode_unlock_i(unlock),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  // behavioural reference
  bit [31:0] m0, m1, dv, s1, s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0 <= 0; m1 <= 0; dv <= 0; s1 <= 0; s2 <= 0;
    end else begin
      s1 <= {26'd0, pad_in};
      s2 <= s1;
      if (we) begin
        case (addr)
          8'h14: dv <= dv | (wdata & MASK);
          8'h18: dv <= dv & ~wdata;
          8'h08: if (unlock) m1 <= wdata & MASK;
          8'h0C: if (unlock) m0 <= wdata & MASK;
          8'h50: if (unlock) m1 <= m1 & ~wdata;
          8'h54: if (unlock) m0 <= m0 | (wdata & MASK);
          8'h58: if (unlock) m0 <= m0 & ~wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h04: return s2;
      8'h08: return m1;
      8'h0C: return m0;
      8'h14: return dv;
      default: return 32'd0;
    endcase
  endfunction

  // per-cycle comparison, well away from both edges
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      for (int p = 0; p < N; p++) begin
        int code;
        bit eo, ev;
        string tag;
        code = {m1[p], m0[p]};
        case (code)
          0: begin eo = 0; ev = 0; tag = "R4"; end
          1: begin eo = 1; ev = dv[p]; tag = "R5"; end
          2: begin eo = !dv[p]; ev = 0; tag = "R6"; end
          default: begin eo = dv[p]; ev = dv[p]; tag = "R7"; end
        endcase
        check(tag, {30'd0, pad_oe[p], pad_out[p]}, {30'd0, eo, ev});
      end
      check(addr == 8'h04 ? "R10" : (addr == 8'h14 ? "R3" : "R2"), rdata, exp_read(addr));
      check("R11", rdata & ~MASK, 32'd0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h0C, r); check("R1", r, 0);
    rd(8'h08, r); check("R1", r, 0);
    rd(8'h14, r); check("R1", r, 0);
    check("R1", {26'd0, pad_oe}, 0);

    // R3 data set/clear, independent of lock
    wr(8'h14, 32'h0000_0025);
    rd(8'h14, r); check("R3", r, 32'h25);
    wr(8'h18, 32'h0000_0001);
    rd(8'h14, r); check("R3", r, 32'h24);

    // R8 locked mode writes ignored
    wr(8'h0C, 32'h3F); wr(8'h08, 32'h3F); wr(8'h54, 32'h3F);
    rd(8'h0C, r); check("R8", r, 0);
    rd(8'h08, r); check("R8", r, 0);
    check("R8", {26'd0, pad_oe}, 0);

    // R9 unlocked direct and alias writes; pins cover all four modes
    unlock = 1'b1;
    wr(8'h0C, 32'hFFFF_FF0A);  // mode0 = 001010, upper bits dropped (R11)
    rd(8'h0C, r); check("R11", r, 32'h0A);
    wr(8'h08, 32'h0000_000C);  // mode1 = 001100
    wr(8'h54, 32'h0000_0001);
    rd(8'h0C, r); check("R9", r, 32'h0B);
    wr(8'h58, 32'h0000_0002);
    rd(8'h0C, r); check("R9", r, 32'h09);
    wr(8'h50, 32'h0000_0004);
    rd(8'h08, r); check("R9", r, 32'h08);
    wr(8'h0C, 32'h0000_002A); wr(8'h08, 32'h0000_003C);
    for (int k = 0; k < 4; k++) wr(8'h14 + 8'(4 * (k & 1)), 32'h15 << (k >> 1));
    unlock = 1'b0;

    // R10 data-in with toggling pads, writes to data-in ignored
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); pad_in = N'($urandom);
    end
    wr(8'h04, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 6'h2D;
    repeat (2) @(negedge clk);
    rd(8'h04, r); check("R10", r, 32'h2D);
    rd(8'h7C, r); check("R2", r, 0);
    rd(8'h18, r); check("R2", r, 0);

    // mixed random phase
    for (int k = 0; k < 600; k++) begin
      logic [7:0] alist [9];
      alist = '{8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h50, 8'h54, 8'h58, 8'h30};
      @(negedge clk);
      unlock = 1'($urandom);
      we = 1'($urandom);
      addr = alist[$urandom % 9];
      wdata = $urandom;
      pad_in = N'($urandom);
    end
    @(negedge clk); we = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule